// File: doc/BRIEF.md
# Bit-Swapping Pseudo-Random Pattern Generator

This block produces pseudo-random test patterns for built-in self-test with fewer output transitions than a plain shift-register generator. A maximal-length Fibonacci feedback shift register steps through every nonzero state. An output stage of 2:1 multiplexers sits after it. The most significant register bit is the select line for that stage. When that bit is zero, the stage exchanges neighbouring pairs of output bits. When it is one, the register bits go out unchanged. Because the multiplexer stage never feeds back into the register, the state sequence is exactly that of the unswapped register. Only the order of bits at the output changes, and that lowers the number of output toggles.

The register width and the feedback tap mask are parameters. The default is a 4-bit register with taps on the first and last stage. The block has a synchronous reset, an enable, and a seed-load strobe with a seed value. It drives the swapped pattern and, for debug, the raw register state. It also has one transition counter per output bit, so that the reduction in switching can be measured from outside.

Top module: `bslfsr_gen`

## Requirements
- R1: After synchronous reset, the register state is all ones, the pattern is all ones and every transition counter reads zero.
- R2: Bit numbering: `state_o[i]` holds stage Q(i+1). On an enabled step without a load, Q1 takes the XOR of all stages whose bit is set in `TAPS`, and every other stage Q(k) takes Q(k-1). With the default taps (Q1 and Q4), the states after 1111 are 0111, 1011, 0101, 1010. These values are written Q1..Q4, so that 0111 is the vector 4'b1110.
- R3: Starting from all ones, the default 4-bit register returns to all ones after exactly 15 enabled steps and does not visit all ones in between. A 5-bit register with taps Q3 and Q5 returns after exactly 31 steps.
- R4: With `en` low and `load` low, the state, the pattern and the counters all hold their values.
- R5: A `load` pulse puts `seed` into the register at the next edge, whatever the value of `en`. A load takes priority over a shift in the same cycle.
- R6: A load with `seed` equal to zero puts all ones into the register instead.
- R7: When the top stage Q(N) is 1, `pattern_o` equals `state_o`.
- R8: When Q(N) is 0, the pattern swaps the pairs (Q1,Q2), (Q3,Q4) and so on, for floor((N-1)/2) pairs. Q(N) is never swapped. For an even N, Q(N-1) passes straight through. Examples for N=4, written Q1..Q4: state 1010 gives 0110, state 0110 gives 1010, state 0100 gives 1000, and state 1000 gives 0100. Example for N=5: state 01110 gives 10110.
- R9: Counter i (bits `[i*CNT_W +: CNT_W]` of `toggle_cnt_o`) adds one in every step where `pattern_o[i]` changes. Reset and load both clear all counters to zero.
- R10: For the default 4-bit configuration, one full period from all ones gives per-bit toggle counts of 8, 4, 8 and 8 (28 in total). A plain register would give 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load `seed` into the register (priority over `en`) |
| seed | input | WIDTH | Seed value; zero is replaced by all ones |
| pattern_o | output | WIDTH | Bit-swapped test pattern |
| state_o | output | WIDTH | Raw register state, for debug |
| toggle_cnt_o | output | WIDTH*CNT_W | Per-bit output transition counters, bit i at `[i*CNT_W +: CNT_W]` |

## Verification
The bench builds two copies of the block. The first uses the default width of 4 with taps Q1 and Q4. It reaches the even-width swap rule, in which Q3 passes through, the period of 15 and the 8/4/8/8 toggle profile. The second uses width 5 with taps Q3 and Q5. It reaches the odd-width rule, in which two pairs are swapped, and a period of 31, so the pair-count arithmetic is checked for both parities. Random enables, loads and seeds, including zero seeds, are checked cycle by cycle against a model of state and counters kept in the bench.

// File: rtl/bslfsr_pkg.sv
package bslfsr_pkg;
  localparam int unsigned DEF_WIDTH = 4;
  localparam int unsigned DEF_CNT_W = 16;

  // Number of adjacent output pairs exchanged when the select stage is zero.
  function automatic int unsigned swap_pairs(input int unsigned width);
    return (width - 1) / 2;
  endfunction
endpackage

// File: rtl/bslfsr_core.sv
module bslfsr_core #(
  parameter int unsigned WIDTH = bslfsr_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = 4'b1001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] state_nxt,
  output logic             advance
);
  localparam logic [WIDTH-1:0] ONES = '1;

  function automatic logic [WIDTH-1:0] step_fn(input logic [WIDTH-1:0] s);
    logic fb;
    fb = ^(s & TAPS);
    return {s[WIDTH-2:0], fb};
  endfunction

  function automatic logic [WIDTH-1:0] seed_fix(input logic [WIDTH-1:0] s);
    return (s == '0) ? ONES : s;
  endfunction

  assign advance = en && !load;

  always_comb begin
    if (load)         state_nxt = seed_fix(seed);
    else if (advance) state_nxt = step_fn(state_q);
    else              state_nxt = state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ONES;
    else     state_q <= state_nxt;
  end
endmodule

// File: rtl/bslfsr_swap.sv
module bslfsr_swap #(
  parameter int unsigned WIDTH = bslfsr_pkg::DEF_WIDTH
) (
  input  logic [WIDTH-1:0] state_i,
  output logic [WIDTH-1:0] pattern_o
);
  localparam int unsigned NPAIRS = bslfsr_pkg::swap_pairs(WIDTH);
  localparam int unsigned FIRST_PASS = 2 * NPAIRS;

  logic do_swap;
  assign do_swap = !state_i[WIDTH-1];

  genvar p, j;
  generate
    for (p = 0; p < NPAIRS; p++) begin : g_pair
      assign pattern_o[2*p]   = do_swap ? state_i[2*p+1] : state_i[2*p];
      assign pattern_o[2*p+1] = do_swap ? state_i[2*p]   : state_i[2*p+1];
    end
    for (j = FIRST_PASS; j < WIDTH; j++) begin : g_pass
      assign pattern_o[j] = state_i[j];
    end
  endgenerate
endmodule

// File: rtl/bslfsr_toggles.sv
module bslfsr_toggles #(
  parameter int unsigned WIDTH = bslfsr_pkg::DEF_WIDTH,
  parameter int unsigned CNT_W = bslfsr_pkg::DEF_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   advance,
  input  logic [WIDTH-1:0]       pat_cur,
  input  logic [WIDTH-1:0]       pat_nxt,
  output logic [WIDTH*CNT_W-1:0] cnt_o
);
  logic [WIDTH-1:0] flip;
  assign flip = pat_cur ^ pat_nxt;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || clear)           cnt_q <= '0;
        else if (advance && flip[i]) cnt_q <= cnt_q + 1'b1;
      end
      assign cnt_o[i*CNT_W +: CNT_W] = cnt_q;
    end
  endgenerate
endmodule

// File: rtl/bslfsr_gen.sv
module bslfsr_gen #(
  parameter int unsigned WIDTH = bslfsr_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = 4'b1001,
  parameter int unsigned CNT_W = bslfsr_pkg::DEF_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   load,
  input  logic [WIDTH-1:0]       seed,
  output logic [WIDTH-1:0]       pattern_o,
  output logic [WIDTH-1:0]       state_o,
  output logic [WIDTH*CNT_W-1:0] toggle_cnt_o
);
  logic [WIDTH-1:0] state_w;
  logic [WIDTH-1:0] state_nxt_w;
  logic [WIDTH-1:0] pat_nxt_w;
  logic             adv_w;

  bslfsr_core #(.WIDTH(WIDTH), .TAPS(TAPS)) core_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .state_q(state_w), .state_nxt(state_nxt_w), .advance(adv_w)
  );

  bslfsr_swap #(.WIDTH(WIDTH)) swap_cur_i (
    .state_i(state_w), .pattern_o(pattern_o)
  );

  bslfsr_swap #(.WIDTH(WIDTH)) swap_nxt_i (
    .state_i(state_nxt_w), .pattern_o(pat_nxt_w)
  );

  bslfsr_toggles #(.WIDTH(WIDTH), .CNT_W(CNT_W)) tog_i (
    .clk(clk), .rst(rst), .clear(load), .advance(adv_w),
    .pat_cur(pattern_o), .pat_nxt(pat_nxt_w), .cnt_o(toggle_cnt_o)
  );

  assign state_o = state_w;
endmodule

// File: rtl/bslfsr_gen_chk.sv
module bslfsr_gen_chk #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic                   load,
  input logic [WIDTH-1:0]       seed,
  input logic [WIDTH-1:0]       pattern_o,
  input logic [WIDTH-1:0]       state_o,
  input logic [WIDTH*CNT_W-1:0] toggle_cnt_o,
  input logic                   adv_w
);
  localparam logic [WIDTH-1:0] ONES = '1;

  p_reset_ones_r1: assert property (@(posedge clk) rst |=> state_o == ONES);

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    adv_w |=> state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0]));

  p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
    state_o != '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> ($stable(state_o) && $stable(toggle_cnt_o)));

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> state_o == $past(seed));

  p_zero_seed_r6: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> state_o == ONES);

  p_passthru_r7: assert property (@(posedge clk) disable iff (rst)
    state_o[WIDTH-1] |-> pattern_o == state_o);

  p_sel_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (pattern_o[WIDTH-1] == state_o[WIDTH-1]) &&
    ($countones(pattern_o) == $countones(state_o)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> toggle_cnt_o == '0);
endmodule

bind bslfsr_gen bslfsr_gen_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
  .pattern_o(pattern_o), .state_o(state_o), .toggle_cnt_o(toggle_cnt_o),
  .adv_w(adv_w)
);

// File: tb/bslfsr_gen_tb_top.sv
module bslfsr_gen_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [3:0] seed4 = '0;
  logic [4:0] seed5 = '0;
  logic [3:0] pat4, st4;
  logic [4:0] pat5, st5;
  logic [4*CW-1:0] cnt4;
  logic [5*CW-1:0] cnt5;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] m4, m5;
  int mc4[4];
  int mc5[5];

  always #5 clk = ~clk;

  bslfsr_gen #(.WIDTH(4), .TAPS(4'b1001), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed4),
    .pattern_o(pat4), .state_o(st4), .toggle_cnt_o(cnt4)
  );

  bslfsr_gen #(.WIDTH(5), .TAPS(5'b10100), .CNT_W(CW)) dut5_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed5),
    .pattern_o(pat5), .state_o(st5), .toggle_cnt_o(cnt5)
  );

  function automatic logic [7:0] msk(input int n);
    return 8'((9'h1 << n) - 1);
  endfunction

  function automatic logic [7:0] mstep(input logic [7:0] s, input int n, input logic [7:0] t);
    logic b;
    b = ^(s & t);
    return ((s << 1) | {7'd0, b}) & msk(n);
  endfunction

  function automatic logic [7:0] mswap(input logic [7:0] s, input int n);
    logic [7:0] r;
    r = s;
    if (s[n-1] == 1'b0)
      for (int p = 0; p < (n - 1) / 2; p++) begin
        r[2*p] = s[2*p+1];
        r[2*p+1] = s[2*p];
      end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "state4", 64'(st4), 64'(m4[3:0]));
    chk(req, "pattern4", 64'(pat4), 64'(mswap(m4, 4)));
    chk(req, "state5", 64'(st5), 64'(m5[4:0]));
    chk(req, "pattern5", 64'(pat5), 64'(mswap(m5, 5)));
    for (int i = 0; i < 4; i++) chk(req, "cnt4", 64'(cnt4[i*CW +: CW]), 64'(mc4[i]));
    for (int i = 0; i < 5; i++) chk(req, "cnt5", 64'(cnt5[i*CW +: CW]), 64'(mc5[i]));
  endtask

  // One clock: drive at negedge, update model at the edge, sample 1 ns later.
  task automatic cycle(input logic e, input logic l, input logic [7:0] s4, input logic [7:0] s5, input string req);
    logic [7:0] n4, n5;
    en = e; load = l; seed4 = s4[3:0]; seed5 = s5[4:0];
    @(posedge clk);
    #1;
    if (l) begin
      m4 = (s4[3:0] == 0) ? 8'h0F : {4'd0, s4[3:0]};
      m5 = (s5[4:0] == 0) ? 8'h1F : {3'd0, s5[4:0]};
      for (int i = 0; i < 4; i++) mc4[i] = 0;
      for (int i = 0; i < 5; i++) mc5[i] = 0;
    end else if (e) begin
      n4 = mstep(m4, 4, 8'h09);
      n5 = mstep(m5, 5, 8'h14);
      for (int i = 0; i < 4; i++) mc4[i] += int'(mswap(n4, 4)[i] ^ mswap(m4, 4)[i]);
      for (int i = 0; i < 5; i++) mc5[i] += int'(mswap(n5, 5)[i] ^ mswap(m5, 5)[i]);
      m4 = n4; m5 = n5;
    end
    compare_all(req);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hit4, hit5, rs;
    rs = $urandom(32'd20240611);
    m4 = 8'h0F; m5 = 8'h1F;
    for (int i = 0; i < 4; i++) mc4[i] = 0;
    for (int i = 0; i < 5; i++) mc5[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    compare_all("R1");
    chk("R1", "pattern4 ones", 64'(pat4), 64'hF);

    // R2/R3/R10: full periods from all ones
    hit4 = 0; hit5 = 0;
    for (int k = 1; k <= 31; k++) begin
      cycle(1, 0, 0, 0, "R2");
      if (k == 1) chk("R2", "first step", 64'(st4), 64'h0E);
      if (k == 4) chk("R2", "fourth step", 64'(st4), 64'h05);
      if (k < 15 && st4 == 4'hF) hit4++;
      if (k < 31 && st5 == 5'h1F) hit5++;
      if (k == 15) begin
        chk("R3", "period4 return", 64'(st4), 64'hF);
        chk("R10", "cnt Q1", 64'(cnt4[0*CW +: CW]), 64'd8);
        chk("R10", "cnt Q2", 64'(cnt4[1*CW +: CW]), 64'd4);
        chk("R10", "cnt Q3", 64'(cnt4[2*CW +: CW]), 64'd8);
        chk("R10", "cnt Q4", 64'(cnt4[3*CW +: CW]), 64'd8);
        chk("R10", "cnt total", 64'(cnt4[0 +: CW] + cnt4[CW +: CW] + cnt4[2*CW +: CW] + cnt4[3*CW +: CW]), 64'd28);
      end
    end
    chk("R3", "early repeat4", 64'(hit4), 64'd0);
    chk("R3", "early repeat5", 64'(hit5), 64'd0);
    chk("R3", "period5 return", 64'(st5), 64'h1F);

    // R4: hold with enable low
    repeat (3) cycle(0, 0, 8'h3, 8'h3, "R4");

    // R5/R8: load with en low, swap examples (Q1..Q4 1010 -> 0110)
    cycle(0, 1, 8'h05, 8'h0E, "R5");
    chk("R8", "1010->0110", 64'(pat4), 64'h6);
    chk("R8", "odd 01110->10110", 64'(pat5), 64'h0D);
    chk("R9", "cleared", 64'(cnt4), 64'd0);
    cycle(0, 1, 8'h06, 8'h01, "R8");
    chk("R8", "0110->1010", 64'(pat4), 64'h5);
    cycle(0, 1, 8'h02, 8'h02, "R8");
    chk("R8", "0100->1000", 64'(pat4), 64'h1);
    cycle(0, 1, 8'h01, 8'h04, "R8");
    chk("R8", "1000->0100", 64'(pat4), 64'h2);
    // R7: top stage set, pass through
    cycle(0, 1, 8'h0D, 8'h19, "R7");
    chk("R7", "passthru4", 64'(pat4), 64'hD);
    chk("R7", "passthru5", 64'(pat5), 64'h19);
    // R5: load beats enable
    cycle(1, 1, 8'h09, 8'h11, "R5");
    chk("R5", "load priority", 64'(st4), 64'h9);
    // R6: zero seed
    cycle(1, 1, 8'h00, 8'h00, "R6");
    chk("R6", "zero seed4", 64'(st4), 64'hF);
    chk("R6", "zero seed5", 64'(st5), 64'h1F);
    // R9: counting after load
    repeat (6) cycle(1, 0, 0, 0, "R9");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      logic e, l;
      logic [7:0] s4, s5;
      e = ($urandom % 4) != 0;
      l = ($urandom % 16) == 0;
      s4 = (($urandom % 4) == 0) ? 8'h0 : 8'($urandom % 16);
      s5 = (($urandom % 4) == 0) ? 8'h0 : 8'($urandom % 32);
      cycle(e, l, s4, s5, "R9");
    end

    // R1: reset again from a running state
    rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    m4 = 8'h0F; m5 = 8'h1F;
    for (int i = 0; i < 4; i++) mc4[i] = 0;
    for (int i = 0; i < 5; i++) mc5[i] = 0;
    #1;
    compare_all("R1");
    finish_run();
  end
endmodule